// File: doc/BRIEF.md
# Sparsified matrix readout serializer

This block sits at the edge of a 16 by 16 pixel matrix whose cells are read out with a passing token. While particles arrive the matrix only records hits; once the gap between trains begins, a start pulse makes the block push the token into the first cell of the chain. The token runs through cells without a hit and stops at the first cell that holds one. That cell drives a one-hot column line and a one-hot row line toward the edge. Its time stamp appears on the buffer of its column.

In that cycle the block encodes the two one-hot lines into a 4-bit column address and a 4-bit row address. It takes the 5-bit time stamp from the buffer of the selected column and loads the 13-bit word into a shift register. It also pulses an advance strobe so that the cell releases the token. The word leaves the block MSB first on one serial line, framed by a valid strobe. The token waits until the word has almost left. A frame ends when the token comes out of the last cell and no word is pending. Only hit cells produce data, so an empty matrix costs just a few cycles.

Top module: `sparse_ro_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, tokenInject, tokenAdvance, serOut, serValid, busy and frameDone are all 0.
- R2: A readoutStart pulse sampled while idle makes tokenInject high for exactly one cycle, the cycle after the sampling edge, and busy rises in that same cycle.
- R3: When a cell holds the token (getXBus bit c and getYBus bit r high), the block captures the word {c[3:0], r[3:0], ts[4:0]}, where ts is tsColumns[5c+4:5c], and pulses tokenAdvance in the capture cycle.
- R4: Each word is sent MSB first on serOut, one bit per clock, with serValid high for exactly 13 cycles per word. A word captured in the last bit cycle of the previous word follows it with no gap.
- R5: tokenAdvance is high only when no word is shifting, or in the cycle that carries the last (13th) bit of the current word.
- R6: Words come out in the order the token reaches the hit cells, one word per hit cell. In the chain, cell (c, r) has position 16r + c.
- R7: When tokenExit is high and no cell holds the token and no bit is pending, frameDone is high for one cycle. busy falls in that same cycle, and busy stays high up to then.
- R8: A frame with no hit cells produces no serValid cycle and still ends with frameDone.
- R9: A readoutStart pulse while busy is high is ignored: no second tokenInject, and the word stream is unchanged.
- R10: serOut is 0 in every cycle in which serValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rstN | input | 1 | Asynchronous reset, active low |
| readoutStart | input | 1 | Pulse that opens the readout phase |
| getXBus | input | 16 | One-hot column line from the cell holding the token |
| getYBus | input | 16 | One-hot row line from the cell holding the token |
| tsColumns | input | 80 | Time stamp buffers, 5 bits per column, column c at bits 5c+4:5c |
| tokenExit | input | 1 | Token has left the last cell of the chain |
| tokenInject | output | 1 | Token into the first cell |
| tokenAdvance | output | 1 | Releases the cell holding the token |
| serOut | output | 1 | Serial data, MSB first |
| serValid | output | 1 | High while serOut carries a word bit |
| busy | output | 1 | Readout phase in progress |
| frameDone | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The last bit of one word can leave in the same cycle that the next hit is captured. Every frame with two or more hits provokes this, and the full matrix provokes it 255 times in a row. The bench judges it by counting serValid runs, which must be exactly one per non-empty frame, and by checking that tokenAdvance only appears with 12 bits of the current word already received. The token exit can also coincide with the last bit. The bench checks that frameDone and the busy fall come in the cycle after that bit, with every expected word already decoded. Hits in the first cell, in the last cell and across a row wrap are included as directed frames.

// File: rtl/sparse_ro_pkg.sv
package sparse_ro_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INJECT = 2'd1,
    ST_SCAN   = 2'd2,
    ST_SHIFT  = 2'd3
  } roState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic stop;
  } roStrobe_t;

endpackage

// File: rtl/sparse_ro_datapath.sv
module sparse_ro_datapath
  import sparse_ro_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int TS_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  roStrobe_t            strobe,
  input  logic [COLS-1:0]      getXBus,
  input  logic [ROWS-1:0]      getYBus,
  input  logic [COLS*TS_W-1:0] tsColumns,
  output logic                 hitPresent,
  output logic                 wordActive,
  output logic                 lastBit,
  output logic                 serOut
);

  localparam int X_W    = $clog2(COLS);
  localparam int Y_W    = $clog2(ROWS);
  localparam int WORD_W = X_W + Y_W + TS_W;
  localparam int CNT_W  = $clog2(WORD_W);

  logic [TS_W-1:0]   tsArr [COLS];
  logic [X_W-1:0]    xAddr;
  logic [Y_W-1:0]    yAddr;
  logic [WORD_W-1:0] capWord;
  logic [WORD_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;

  // unpack the per-column time stamp buffers
  for (genvar c = 0; c < COLS; c++) begin : g_tsCol
    assign tsArr[c] = tsColumns[c*TS_W +: TS_W];
  end

  // one-hot to binary address encoders
  always_comb begin
    xAddr = '0;
    for (int c = 0; c < COLS; c++) begin
      if (getXBus[c]) xAddr = xAddr | X_W'(c);
    end
  end

  always_comb begin
    yAddr = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (getYBus[r]) yAddr = yAddr | Y_W'(r);
    end
  end

  assign hitPresent = |getXBus;
  assign capWord    = {xAddr, yAddr, tsArr[xAddr]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      bitCnt     <= '0;
      wordActive <= 1'b0;
    end else if (strobe.load) begin
      shReg      <= capWord;
      bitCnt     <= '0;
      wordActive <= 1'b1;
    end else if (strobe.shift) begin
      shReg      <= {shReg[WORD_W-2:0], 1'b0};
      bitCnt     <= bitCnt + 1'b1;
    end else if (strobe.stop) begin
      wordActive <= 1'b0;
    end
  end

  assign lastBit = wordActive && (bitCnt == CNT_W'(WORD_W-1));
  assign serOut  = wordActive & shReg[WORD_W-1];

  // R4: a word ends only after its final bit position
  a_r4_full_word: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordActive) |-> ($past(bitCnt) == CNT_W'(WORD_W-1)));

  // R3: a held token drives exactly one column and one row line
  a_r3_single_cell: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> ($countones(getXBus) == 1 && $countones(getYBus) == 1));

  // R4: bit counter never runs past the word length
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    wordActive |-> (bitCnt <= CNT_W'(WORD_W-1)));

endmodule

// File: rtl/sparse_ro_control.sv
module sparse_ro_control
  import sparse_ro_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      readoutStart,
  input  logic      tokenExit,
  input  logic      hitPresent,
  input  logic      wordActive,
  input  logic      lastBit,
  output roStrobe_t strobe,
  output logic      tokenInject,
  output logic      tokenAdvance,
  output logic      busy,
  output logic      frameDone
);

  roState_t state, nxtState;
  logic     doneSet;

  always_comb begin
    nxtState = state;
    strobe   = '0;
    doneSet  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (readoutStart) nxtState = ST_INJECT;
      end
      ST_INJECT: begin
        nxtState = ST_SCAN;
      end
      ST_SCAN: begin
        if (hitPresent) begin
          strobe.load = 1'b1;
          nxtState    = ST_SHIFT;
        end else if (tokenExit) begin
          doneSet  = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_SHIFT: begin
        if (!lastBit) begin
          strobe.shift = 1'b1;
        end else if (hitPresent) begin
          strobe.load = 1'b1;
        end else if (tokenExit) begin
          strobe.stop = 1'b1;
          doneSet     = 1'b1;
          nxtState    = ST_IDLE;
        end else begin
          strobe.stop = 1'b1;
          nxtState    = ST_SCAN;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
    end else begin
      state     <= nxtState;
      frameDone <= doneSet;
    end
  end

  assign tokenInject  = (state == ST_INJECT);
  assign tokenAdvance = strobe.load;
  assign busy         = (state != ST_IDLE);

  // R2: injection is a single-cycle pulse
  a_r2_inject_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tokenInject |=> !tokenInject);

  // R9: no injection can follow a busy cycle
  a_r9_no_reinject: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !tokenInject);

  // R5: token released only when the shifter is free or on its last bit
  a_r5_capture_gate: assert property (@(posedge clk) disable iff (!rstN)
    tokenAdvance |-> (!wordActive || lastBit));

  // R7: busy drops together with the done pulse
  a_r7_busy_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> frameDone);

  // R7: no data left in flight at the end of a frame
  a_r7_drained: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !wordActive);

endmodule

// File: rtl/sparse_ro_serializer.sv
module sparse_ro_serializer
  import sparse_ro_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int TS_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 readoutStart,
  input  logic [COLS-1:0]      getXBus,
  input  logic [ROWS-1:0]      getYBus,
  input  logic [COLS*TS_W-1:0] tsColumns,
  input  logic                 tokenExit,
  output logic                 tokenInject,
  output logic                 tokenAdvance,
  output logic                 serOut,
  output logic                 serValid,
  output logic                 busy,
  output logic                 frameDone
);

  roStrobe_t strobe;
  logic      hitPresent;
  logic      wordActive;
  logic      lastBit;

  sparse_ro_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .readoutStart (readoutStart),
    .tokenExit    (tokenExit),
    .hitPresent   (hitPresent),
    .wordActive   (wordActive),
    .lastBit      (lastBit),
    .strobe       (strobe),
    .tokenInject  (tokenInject),
    .tokenAdvance (tokenAdvance),
    .busy         (busy),
    .frameDone    (frameDone)
  );

  sparse_ro_datapath #(
    .COLS (COLS),
    .ROWS (ROWS),
    .TS_W (TS_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .getXBus    (getXBus),
    .getYBus    (getYBus),
    .tsColumns  (tsColumns),
    .hitPresent (hitPresent),
    .wordActive (wordActive),
    .lastBit    (lastBit),
    .serOut     (serOut)
  );

  assign serValid = wordActive;

  // R10: serial line quiet outside a word
  a_r10_quiet_line: assert property (@(posedge clk) disable iff (!rstN)
    !serValid |-> !serOut);

  // R4: serial data only during readout
  a_r4_valid_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    serValid |-> busy);

endmodule

// File: tb/sparse_ro_serializer_tb.sv
module sparse_ro_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCELL      = 256;
  localparam int WDOG_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readoutStart = 1'b0;
  logic [15:0] getXBus, getYBus;
  logic [79:0] tsColumns;
  logic        tokenExit;
  logic        tokenInject, tokenAdvance, serOut, serValid, busy, frameDone;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // behavioural matrix
  logic [NCELL-1:0] hits = '0;
  logic [4:0]       cellTs [NCELL];
  logic             tokenActive = 1'b0;
  logic             found;
  logic [7:0]       firstIdx;

  // expected stream and receiver state
  logic [12:0] expWords [NCELL];
  int          expCount;
  int          rxCount, rxBits, runs;
  logic [12:0] rxWord;
  logic        prevValid;
  logic        collecting = 1'b0;

  sparse_ro_serializer dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .readoutStart (readoutStart),
    .getXBus      (getXBus),
    .getYBus      (getYBus),
    .tsColumns    (tsColumns),
    .tokenExit    (tokenExit),
    .tokenInject  (tokenInject),
    .tokenAdvance (tokenAdvance),
    .serOut       (serOut),
    .serValid     (serValid),
    .busy         (busy),
    .frameDone    (frameDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WDOG_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // token position: first remaining hit in chain order 16*row + col
  always_comb begin
    found    = 1'b0;
    firstIdx = '0;
    for (int i = 0; i < NCELL; i++) begin
      if (!found && tokenActive && hits[i]) begin
        found    = 1'b1;
        firstIdx = 8'(i);
      end
    end
    getXBus   = found ? (16'h1 << firstIdx[3:0]) : 16'h0;
    getYBus   = found ? (16'h1 << firstIdx[7:4]) : 16'h0;
    tokenExit = tokenActive && !found;
    for (int c = 0; c < 16; c++) begin
      if (found && firstIdx[3:0] == 4'(c)) tsColumns[c*5 +: 5] = cellTs[firstIdx];
      else tsColumns[c*5 +: 5] = 5'(c) ^ 5'h15;
    end
  end

  always @(posedge clk) begin
    if (tokenInject) tokenActive <= 1'b1;
    if (frameDone) tokenActive <= 1'b0;
    if (tokenAdvance && found) hits[firstIdx] <= 1'b0;
  end

  // serial receiver and stream checks
  always @(negedge clk) begin
    if (collecting) begin
      if (tokenAdvance) check(!serValid || rxBits == 12, "R5 advance during shift", rxBits, 12);
      if (!serValid) begin
        if (serOut) check(1'b0, "R10 line quiet", 1, 0);
      end
      if (serValid && !prevValid) runs++;
      if (serValid) begin
        rxWord = {rxWord[11:0], serOut};
        rxBits++;
        if (rxBits == 13) begin
          if (rxCount < expCount)
            check(rxWord == expWords[rxCount], "R3/R4/R6 word", int'(rxWord), int'(expWords[rxCount]));
          else
            check(1'b0, "R6 extra word", rxCount, expCount);
          rxCount++;
          rxBits = 0;
        end
      end
      prevValid = serValid;
    end
  end

  function automatic logic [12:0] mkWord(input int idx, input logic [4:0] ts);
    return {4'(idx % 16), 4'(idx / 16), ts};
  endfunction

  task automatic runFrame(input logic [NCELL-1:0] pattern, input bit probeStart);
    collecting = 1'b0;
    hits     = pattern;
    expCount = 0;
    for (int i = 0; i < NCELL; i++) begin
      cellTs[i] = 5'($urandom);
      if (pattern[i]) begin
        expWords[expCount] = mkWord(i, cellTs[i]);
        expCount++;
      end
    end
    rxCount = 0; rxBits = 0; runs = 0; rxWord = '0; prevValid = 1'b0;
    collecting = 1'b1;
    readoutStart = 1'b1;
    @(negedge clk);
    readoutStart = 1'b0;
    check(tokenInject == 1'b1, "R2 inject high", tokenInject, 1);
    check(busy == 1'b1, "R2 busy rises", busy, 1);
    @(negedge clk);
    check(tokenInject == 1'b0, "R2 inject one cycle", tokenInject, 0);
    if (probeStart && expCount > 0) begin
      readoutStart = 1'b1;
      @(negedge clk);
      readoutStart = 1'b0;
      check(tokenInject == 1'b0, "R9 start while busy", tokenInject, 0);
    end
    for (int w = 0; w < 6000; w++) begin
      if (frameDone) break;
      if (!busy) check(1'b0, "R7 busy early fall", busy, 1);
      @(negedge clk);
    end
    check(frameDone == 1'b1, "R7 frame done", frameDone, 1);
    check(busy == 1'b0, "R7 busy low at done", busy, 0);
    check(rxCount == expCount, "R6/R8 word count", rxCount, expCount);
    check(rxBits == 0, "R4 no partial word", rxBits, 0);
    check(runs == (expCount > 0 ? 1 : 0), "R4 back to back runs", runs, (expCount > 0 ? 1 : 0));
    @(negedge clk);
    check(frameDone == 1'b0, "R7 done one cycle", frameDone, 0);
    check(serValid == 1'b0, "R8 no trailing data", serValid, 0);
    collecting = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [NCELL-1:0] pat;
    int density;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check({tokenInject, tokenAdvance, serOut, serValid, busy, frameDone} == 6'b0,
          "R1 outputs in reset", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({tokenInject, tokenAdvance, serOut, serValid, busy, frameDone} == 6'b0,
          "R1 outputs after reset",
          int'({tokenInject, tokenAdvance, serOut, serValid, busy, frameDone}), 0);

    // R8 empty frame
    runFrame('0, 1'b0);
    // R3 first cell and last cell alone
    pat = '0; pat[0] = 1'b1;   runFrame(pat, 1'b1);
    pat = '0; pat[255] = 1'b1; runFrame(pat, 1'b0);
    // R6 row wrap neighbours
    pat = '0; pat[15] = 1'b1; pat[16] = 1'b1; runFrame(pat, 1'b1);
    // R4 full matrix, continuous stream
    runFrame('1, 1'b1);

    for (int f = 0; f < 20; f++) begin
      density = int'($urandom % 40);
      for (int i = 0; i < NCELL; i++) pat[i] = (($urandom % 100) < density);
      runFrame(pat, f[0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule